// File: doc/BRIEF.md
# Cart Running-Total Datapath

This block keeps the running bill of a shopping cart. A single 32-entry table holds both item prices and coupon amounts; each entry stores a 14-bit value and a tag bit saying whether it is a price (tag 0) or a coupon (tag 1). The entry address is the kind bit `kind_i` placed above the 4-bit item code `code_i`. The kind bit is stored as the tag when the entry is written.

A 3-bit operation code picks one action per clock cycle. The actions are: write a table entry, add an item, remove an item, apply a coupon, or check out. All operands arrive on shared inputs. `data_i` carries the value being written, or the tax percentage at checkout. Add, remove and coupon share one 14-bit adder, which subtracts when its carry-in is driven high. Checkout multiplies the 14-bit total by (100 + tax percent), so the 21-bit result is scaled by 100. After checkout the cart is closed until reset.

All outputs are registered. The effect of an operation presented before a rising clock edge is visible right after that edge.

Top module: `cart_total_top`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `total_o`, `last_o` and `err_o` are 0, and every table entry holds value 0 with tag 0.
- R2: Opcode 1 (write) stores `data_i` and tag `kind_i` at address {`kind_i`,`code_i`}. `total_o`, `last_o` and `err_o` do not change; `err_o` stays 0.
- R3: Opcode 2 (add) reads entry {`kind_i`,`code_i`}. If the entry's tag is 0, the entry value is added to the total modulo 2^14 and `last_o` takes the entry value.
- R4: Opcode 3 (remove) reads the same way. If the entry's tag is 0, the entry value is subtracted from the total modulo 2^14 and `last_o` takes the entry value.
- R5: Opcode 4 (coupon) reads the same way. If the entry's tag is 1, the entry value is subtracted from the total modulo 2^14 and `last_o` takes the entry value.
- R6: An add or remove that reads an entry with tag 1, or a coupon that reads an entry with tag 0, leaves `total_o` and `last_o` unchanged. It raises `err_o` for exactly the cycle after that operation.
- R7: Opcode 5 (checkout) sets `total_o` to total × (100 + `data_i[6:0]`), 21 bits wide, for tax values 0 to 27, and closes the cart.
- R8: While the cart is closed, opcodes 2 to 5 change neither `total_o` nor `last_o` and never raise `err_o`. Writes still update the table. Only reset reopens the cart.
- R9: Opcodes 0, 6 and 7 leave every output unchanged, except that `err_o` returns to 0.
- R10: While the cart is open, bits 20:14 of `total_o` are 0. A subtraction below zero wraps, for example 0 − 100 gives 16284.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 3 | Operation code |
| kind_i | input | 1 | Entry kind / address MSB: 0 price, 1 coupon |
| code_i | input | 4 | Item code, address low bits |
| data_i | input | 14 | Write value, or tax percent in bits 6:0 at checkout |
| last_o | output | 14 | Most recently looked-up value |
| total_o | output | 21 | Running total, or scaled product after checkout |
| err_o | output | 1 | One-cycle kind-mismatch flag |

## Verification
The assertions check these rules on every cycle:
- no-op and write cycles hold the total;
- a raised error flag comes with an unchanged total;
- the product at checkout is exact;
- a closed cart ignores further operations;
- the upper total bits stay clear while the cart is open.

Only the bench scenarios can show the rest: that table contents written earlier are the values later added, removed or discounted, that the modulo-2^14 wrap happens, and that reset clears both the table and the closed state.

// File: rtl/cart_pkg.sv
package cart_pkg;
  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_WR  = 3'd1,
    OP_ADD = 3'd2,
    OP_DEL = 3'd3,
    OP_CPN = 3'd4,
    OP_CHK = 3'd5
  } op_e;

  localparam logic KIND_PRICE  = 1'b0;
  localparam logic KIND_COUPON = 1'b1;
endpackage

// File: rtl/cart_table.sv
module cart_table #(
  parameter int ADDR_W = 5,
  parameter int VAL_W  = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [VAL_W-1:0]  wdata_i,
  input  logic              wtag_i,
  output logic [VAL_W-1:0]  rdata_o,
  output logic              rtag_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [VAL_W-1:0] val_q [DEPTH];
  logic [DEPTH-1:0] tag_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        val_q[i] <= '0;
        tag_q[i] <= 1'b0;
      end else if (we_i && addr_i == ADDR_W'(i)) begin
        val_q[i] <= wdata_i;
        tag_q[i] <= wtag_i;
      end
    end
  end

  assign rdata_o = val_q[addr_i];
  assign rtag_o  = tag_q[addr_i];
endmodule

// File: rtl/cart_addsub.sv
module cart_addsub #(
  parameter int W = 14
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o
);
  // cin=1: invert b and add one -> a - b
  logic [W-1:0] b_x;
  assign b_x   = b_i ^ {W{cin_i}};
  assign sum_o = a_i + b_x + W'(cin_i);
endmodule

// File: rtl/cart_mul.sv
module cart_mul #(
  parameter int AW = 14,
  parameter int BW = 7
) (
  input  logic [AW-1:0]    a_i,
  input  logic [BW-1:0]    b_i,
  output logic [AW+BW-1:0] p_o
);
  localparam int PW = AW + BW;

  logic [PW-1:0] acc [BW+1];
  assign acc[0] = '0;

  for (genvar i = 0; i < BW; i++) begin : g_pp
    logic [PW-1:0] pp;
    assign pp       = b_i[i] ? (PW'(a_i) << i) : '0;
    assign acc[i+1] = acc[i] + pp;
  end

  assign p_o = acc[BW];
endmodule

// File: rtl/cart_total_top.sv
module cart_total_top
  import cart_pkg::*;
#(
  parameter int CODE_W = 4,
  parameter int VAL_W  = 14,
  parameter int TAX_W  = 7,
  parameter int BASE   = 100
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [2:0]             op_i,
  input  logic                   kind_i,
  input  logic [CODE_W-1:0]      code_i,
  input  logic [VAL_W-1:0]       data_i,
  output logic [VAL_W-1:0]       last_o,
  output logic [VAL_W+TAX_W-1:0] total_o,
  output logic                   err_o
);
  localparam int ADDR_W = CODE_W + 1;
  localparam int TOT_W  = VAL_W + TAX_W;

  op_e               op;
  logic [ADDR_W-1:0] addr;
  logic [VAL_W-1:0]  rd_val, sum;
  logic              rd_tag, want_tag, lookup, tag_ok, sub;
  logic [TAX_W-1:0]  factor;
  logic [TOT_W-1:0]  prod, total_q;
  logic [VAL_W-1:0]  last_q;
  logic              err_q, closed_q;

  assign op   = op_e'(op_i);
  assign addr = {kind_i, code_i};

  cart_table #(.ADDR_W(ADDR_W), .VAL_W(VAL_W)) i_table (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (op == OP_WR),
    .addr_i  (addr),
    .wdata_i (data_i),
    .wtag_i  (kind_i),
    .rdata_o (rd_val),
    .rtag_o  (rd_tag)
  );

  always_comb begin
    lookup   = 1'b0;
    sub      = 1'b0;
    want_tag = KIND_PRICE;
    unique case (op)
      OP_ADD: lookup = 1'b1;
      OP_DEL: begin lookup = 1'b1; sub = 1'b1; end
      OP_CPN: begin lookup = 1'b1; sub = 1'b1; want_tag = KIND_COUPON; end
      default: ;
    endcase
  end

  assign tag_ok = (rd_tag == want_tag);
  assign factor = data_i[TAX_W-1:0] + TAX_W'(BASE);

  cart_addsub #(.W(VAL_W)) i_addsub (
    .a_i   (total_q[VAL_W-1:0]),
    .b_i   (rd_val),
    .cin_i (sub),
    .sum_o (sum)
  );

  cart_mul #(.AW(VAL_W), .BW(TAX_W)) i_mul (
    .a_i (total_q[VAL_W-1:0]),
    .b_i (factor),
    .p_o (prod)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      total_q  <= '0;
      last_q   <= '0;
      err_q    <= 1'b0;
      closed_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      if (!closed_q) begin
        if (lookup) begin
          if (tag_ok) begin
            total_q <= TOT_W'(sum);
            last_q  <= rd_val;
          end else begin
            err_q <= 1'b1;
          end
        end else if (op == OP_CHK) begin
          total_q  <= prod;
          closed_q <= 1'b1;
        end
      end
    end
  end

  assign total_o = total_q;
  assign last_o  = last_q;
  assign err_o   = err_q;
endmodule

// File: rtl/cart_total_chk.sv
module cart_total_chk #(
  parameter int VAL_W = 14,
  parameter int TAX_W = 7,
  parameter int BASE  = 100
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [2:0]             op_i,
  input logic [VAL_W-1:0]       data_i,
  input logic [VAL_W-1:0]       last_o,
  input logic [VAL_W+TAX_W-1:0] total_o,
  input logic                   err_o
);
  localparam int TOT_W = VAL_W + TAX_W;

  logic closed_seen;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) closed_seen <= 1'b0;
    else if (op_i == 3'd5) closed_seen <= 1'b1;
  end

  // R2
  hold_on_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd0 || op_i == 3'd1 || op_i >= 3'd6) |=> ($stable(total_o) && $stable(last_o)));

  // R6
  err_holds_total_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> ($stable(total_o) && $stable(last_o)));

  // R7
  checkout_product_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == 3'd5 && !closed_seen) |=>
      total_o == TOT_W'($past(total_o[VAL_W-1:0])) *
                 TOT_W'(TAX_W'($past(data_i[TAX_W-1:0]) + TAX_W'(BASE))));

  // R8
  closed_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    closed_seen |=> ($stable(total_o) && $stable(last_o) && !err_o));

  // R10
  open_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !closed_seen |-> total_o[TOT_W-1:VAL_W] == '0);
endmodule

bind cart_total_top cart_total_chk #(.VAL_W(VAL_W), .TAX_W(TAX_W), .BASE(BASE)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .op_i    (op_i),
  .data_i  (data_i),
  .last_o  (last_o),
  .total_o (total_o),
  .err_o   (err_o)
);

// File: tb/test_cart_total_top.sv
module test_cart_total_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op = 3'd0;
  logic        kind = 1'b0;
  logic [3:0]  code = 4'd0;
  logic [13:0] data = 14'd0;
  logic [13:0] last;
  logic [20:0] total;
  logic        err;
  int total_n = 0;
  int bad_n = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cart_total_top i_cart_total_top (
    .clk_i(clk), .rst_ni(rst_n), .op_i(op), .kind_i(kind), .code_i(code),
    .data_i(data), .last_o(last), .total_o(total), .err_o(err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total_n++;
    if (act != exp) begin
      bad_n++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // drive one op at negedge, sample at next negedge, then idle
  task automatic do_op(input logic [2:0] o, input logic k, input logic [3:0] c,
                       input logic [13:0] d);
    @(negedge clk);
    op = o; kind = k; code = c; data = d;
    @(negedge clk);
    op = 3'd0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 total in reset", total, 0);
    chk("R1 last in reset", last, 0);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    do_op(3'd1, 1'b0, 4'h8, 14'd500);
    chk("R2 write keeps total", total, 0);
    chk("R2 write keeps last", last, 0);
    do_op(3'd1, 1'b0, 4'hA, 14'd750);
    do_op(3'd1, 1'b0, 4'h0, 14'd900);
    do_op(3'd1, 1'b1, 4'h0, 14'd20);
    chk("R2 write no err", err, 0);
  endtask

  task automatic t_shop();
    do_op(3'd2, 1'b0, 4'h8, 0);
    chk("R3 add 500", total, 500);
    chk("R3 last 500", last, 500);
    do_op(3'd2, 1'b0, 4'hA, 0);
    chk("R3 add 750", total, 1250);
    do_op(3'd2, 1'b0, 4'h0, 0);
    chk("R3 add 900", total, 2150);
    do_op(3'd3, 1'b0, 4'hA, 0);
    chk("R4 remove 750", total, 1400);
    chk("R4 last 750", last, 750);
    do_op(3'd5 + 3'd1, 1'b0, 4'h8, 0);
    chk("R9 opcode 6 holds total", total, 1400);
    do_op(3'd4, 1'b1, 4'h0, 0);
    chk("R5 coupon 20", total, 1380);
    chk("R5 last 20", last, 20);
  endtask

  task automatic t_mismatch();
    do_op(3'd2, 1'b1, 4'h0, 0);
    chk("R6 add on coupon err", err, 1);
    chk("R6 add on coupon total", total, 1380);
    chk("R6 add on coupon last", last, 20);
    @(negedge clk);
    chk("R6 err one cycle", err, 0);
    do_op(3'd4, 1'b0, 4'h8, 0);
    chk("R6 coupon on price err", err, 1);
    chk("R6 coupon on price total", total, 1380);
    do_op(3'd0, 1'b0, 4'h0, 0);
    chk("R9 nop clears err", err, 0);
  endtask

  task automatic t_checkout();
    do_op(3'd5, 1'b0, 4'h0, 14'd3);
    chk("R7 checkout 3pct", total, 142140);
    do_op(3'd2, 1'b0, 4'h8, 0);
    chk("R8 add after close total", total, 142140);
    chk("R8 add after close last", last, 20);
    do_op(3'd4, 1'b0, 4'h8, 0);
    chk("R8 mismatch after close no err", err, 0);
    do_op(3'd5, 1'b0, 4'h0, 14'd3);
    chk("R8 second checkout ignored", total, 142140);
  endtask

  task automatic t_wrap();
    do_reset();
    do_op(3'd2, 1'b0, 4'h8, 0);
    chk("R1 table cleared by reset", total, 0);
    do_op(3'd1, 1'b0, 4'h1, 14'd100);
    do_op(3'd3, 1'b0, 4'h1, 0);
    chk("R10 wrap below zero", total, 16284);
    chk("R10 last 100", last, 100);
    do_op(3'd5, 1'b0, 4'h0, 14'd0);
    chk("R7 checkout 0pct", total, 1628400);
  endtask

  task automatic t_max();
    do_reset();
    do_op(3'd1, 1'b0, 4'h2, 14'd16383);
    do_op(3'd2, 1'b0, 4'h2, 0);
    chk("R3 add max", total, 16383);
    do_op(3'd5, 1'b0, 4'h0, 14'd27);
    chk("R7 checkout 27pct max", total, 2080641);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    do_reset();
    t_fill();
    t_shop();
    t_mismatch();
    t_checkout();
    t_wrap();
    t_max();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total_n, bad_n);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total_n++;
      bad_n++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("  test done: total=%0d bad=%0d", total_n, bad_n);
      $finish;
    end
  end
endmodule